// File: doc/BRIEF.md
# Serial Divider Programming Register

This block takes a three-wire serial programming stream for a frequency synthesizer and turns it into parallel settings. A serial clock, a serial data line and a latch strobe arrive from outside the chip. All three are brought into the system clock domain through a synchronizer chain, and their rising edges are detected there. Each rising edge of the serial clock shifts one data bit into an 18-bit shift register. The most significant bit of the word is sent first.

When the latch strobe rises, the bit that was shifted in last is treated as a destination selector. If it is 0, the 17 bits above it are loaded into the divider register. That register is decoded into four outputs: a 10-bit main count, a 5-bit swallow count, a counter-reset control and a power-down control. The block also raises a flag whenever the main count it holds is below the lowest legal value, which is 3.

If the selector bit is 1, the same 17 bits go to a separate reference word output, and the divider register keeps its value. Nothing downstream of these registers (the counters, the prescaler) belongs to this block.

Top module: `ser_prog_reg`

## Requirements
- R1: Each rising edge of `ser_clk`, seen after synchronization, shifts `ser_data` into an 18-bit register, most significant bit first. Only the last 18 bits shifted in before a latch matter.
- R2: The destination is selected by shift-register bit 0, which is the last bit shifted in. A 0 selects the divider register and a 1 selects the reference word.
- R3: When the selector is 0, a latch loads the divider fields from the shift register. `div_b` is taken from bits 17..8, `div_a` from bits 7..3, `cnt_reset` from bit 2 and `power_down` from bit 1.
- R4: When the selector is 1, a latch loads shift-register bits 17..1 into `ref_word`, and the divider outputs do not change. When the selector is 0, `ref_word` does not change.
- R5: Outputs change only on a rising edge of `ser_le`. Keeping `ser_le` high while more bits are shifted in leaves every output unchanged.
- R6: `b_invalid` is 1 exactly when the `div_b` value currently held is 0, 1 or 2.
- R7: After reset, all field outputs and `ref_word` are 0, and `b_invalid` is 1.
- R8: A latch takes effect at the rising `clk` edge numbered SYNC_STAGES+1 after the `ser_le` pin goes high, which is the 3rd edge with the default settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe, acts on its rising edge |
| div_b | output | 10 | Main (B) count |
| div_a | output | 5 | Swallow (A) count |
| cnt_reset | output | 1 | Counter-reset control |
| power_down | output | 1 | Power-down control |
| b_invalid | output | 1 | Held main count is below 3 |
| ref_word | output | 17 | Word for the reference register |

## Verification
Each serial pin passes through SYNC_STAGES flops and one edge-detect flop before it reaches a register. A latch therefore appears on the outputs at the third `clk` edge after the strobe pin rises, and one shifted bit is stored on the same schedule. The bench changes each serial level on a falling clock edge and holds it for several cycles. It samples outputs only after at least six cycles have passed since the last strobe edge, so every result it checks has already landed. A separate set of directed checks examines the outputs while the strobe is held high and extra bits are shifted in, to confirm nothing moves before the next rising edge.

// File: rtl/ser_prog_pkg.sv
package ser_prog_pkg;
   localparam int SHIFT_W_DEF = 18;
   localparam int B_W_DEF     = 10;
   localparam int A_W_DEF     = 5;
   localparam int CTL_W_DEF   = 2;
   localparam int B_MIN_DEF   = 3;
   localparam int SYNC_DEF    = 2;

   typedef enum logic {
      DEST_DIV = 1'b0,
      DEST_REF = 1'b1
   } dest_e;
endpackage

// File: rtl/ser_prog_sync.sv
module ser_prog_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 1) begin : g_bad
         $error("ser_prog_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= d;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[STAGES-1];
   end

   assign q    = chain[STAGES-1];
   assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/ser_prog_shift.sv
module ser_prog_shift #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (shift_en) q <= {q[W-2:0], din};
   end
endmodule

// File: rtl/ser_prog_div.sv
module ser_prog_div #(
   parameter int B_W   = 10,
   parameter int A_W   = 5,
   parameter int B_MIN = 3,
   localparam int WORD_W = B_W + A_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   output logic [B_W-1:0]    b_cnt,
   output logic [A_W-1:0]    a_cnt,
   output logic              crst,
   output logic              pdwn,
   output logic              b_bad
);
   logic [B_W-1:0] b_next;
   assign b_next = word[WORD_W-1 -: B_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_cnt <= '0;
         a_cnt <= '0;
         crst  <= 1'b0;
         pdwn  <= 1'b0;
         b_bad <= 1'b1;
      end else if (load) begin
         b_cnt <= b_next;
         a_cnt <= word[2 +: A_W];
         crst  <= word[1];
         pdwn  <= word[0];
         b_bad <= (int'(b_next) < B_MIN);
      end
   end
endmodule

// File: rtl/ser_prog_reg.sv
module ser_prog_reg
   import ser_prog_pkg::*;
#(
   parameter int SHIFT_W     = SHIFT_W_DEF,
   parameter int B_W         = B_W_DEF,
   parameter int A_W         = A_W_DEF,
   parameter int CTL_W       = CTL_W_DEF,
   parameter int B_MIN       = B_MIN_DEF,
   parameter int SYNC_STAGES = SYNC_DEF,
   localparam int DATA_W     = SHIFT_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_le,
   output logic [B_W-1:0]    div_b,
   output logic [A_W-1:0]    div_a,
   output logic              cnt_reset,
   output logic              power_down,
   output logic              b_invalid,
   output logic [DATA_W-1:0] ref_word
);
   generate
      if (B_W + A_W + CTL_W != DATA_W) begin : g_bad_fields
         $error("ser_prog_reg: field widths must fill the data word");
      end
      if (CTL_W != 2) begin : g_bad_ctl
         $error("ser_prog_reg: control word must be two bits");
      end
      if (B_MIN < 1 || B_MIN >= (1 << B_W)) begin : g_bad_min
         $error("ser_prog_reg: B_MIN out of range");
      end
   endgenerate

   logic               sclk_rise;
   logic               sclk_q;
   logic               sdat_q;
   logic               sdat_rise;
   logic               le_q;
   logic               le_rise;
   logic [SHIFT_W-1:0] shift_q;
   dest_e              dest;
   logic               load_div;
   logic               load_ref;

   ser_prog_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(sclk_q), .rise(sclk_rise));
   ser_prog_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .d(ser_data), .q(sdat_q), .rise(sdat_rise));
   ser_prog_sync #(.STAGES(SYNC_STAGES)) u_sync_le (
      .clk(clk), .rst_n(rst_n), .d(ser_le), .q(le_q), .rise(le_rise));

   ser_prog_shift #(.W(SHIFT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise), .din(sdat_q), .q(shift_q));

   assign dest     = dest_e'(shift_q[0]);
   assign load_div = le_rise && (dest == DEST_DIV);
   assign load_ref = le_rise && (dest == DEST_REF);

   ser_prog_div #(.B_W(B_W), .A_W(A_W), .B_MIN(B_MIN)) u_div (
      .clk(clk), .rst_n(rst_n), .load(load_div), .word(shift_q[SHIFT_W-1:1]),
      .b_cnt(div_b), .a_cnt(div_a), .crst(cnt_reset), .pdwn(power_down),
      .b_bad(b_invalid));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ref_word <= '0;
      else if (load_ref) ref_word <= shift_q[SHIFT_W-1:1];
   end
endmodule

// File: rtl/ser_prog_reg_chk.sv
module ser_prog_reg_chk #(
   parameter int SHIFT_W = 18,
   parameter int B_W     = 10,
   parameter int A_W     = 5,
   parameter int B_MIN   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               le_rise,
   input logic               sclk_rise,
   input logic [SHIFT_W-1:0] shift_q,
   input logic [B_W-1:0]     div_b,
   input logic [A_W-1:0]     div_a,
   input logic               cnt_reset,
   input logic               power_down,
   input logic               b_invalid,
   input logic [SHIFT_W-2:0] ref_word
);
   logic [SHIFT_W-2:0] div_all;
   assign div_all = {div_b, div_a, cnt_reset, power_down};

   AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> shift_q[SHIFT_W-1:1] == $past(shift_q[SHIFT_W-2:0])); // R1
   AST_DIV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      le_rise && !shift_q[0] |=> div_all == $past(shift_q[SHIFT_W-1:1])); // R3
   AST_REF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      le_rise && shift_q[0] |=> ref_word == $past(shift_q[SHIFT_W-1:1])); // R2
   AST_DIV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      le_rise && shift_q[0] |=> $stable(div_all)); // R4
   AST_REF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      le_rise && !shift_q[0] |=> $stable(ref_word)); // R4
   AST_NO_LATCH_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !le_rise |=> $stable(div_all) && $stable(ref_word) && $stable(b_invalid)); // R5
   AST_B_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      b_invalid == (int'(div_b) < B_MIN)); // R6
endmodule

bind ser_prog_reg ser_prog_reg_chk #(
   .SHIFT_W(SHIFT_W), .B_W(B_W), .A_W(A_W), .B_MIN(B_MIN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .le_rise(le_rise), .sclk_rise(sclk_rise),
   .shift_q(shift_q), .div_b(div_b), .div_a(div_a), .cnt_reset(cnt_reset),
   .power_down(power_down), .b_invalid(b_invalid), .ref_word(ref_word));

// File: tb/tb_ser_prog_reg.sv
module tb_ser_prog_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_data = 1'b0;
   logic        ser_le = 1'b0;
   logic [9:0]  div_b;
   logic [4:0]  div_a;
   logic        cnt_reset;
   logic        power_down;
   logic        b_invalid;
   logic [16:0] ref_word;

   int checks = 0;
   int fails  = 0;

   logic [9:0]  e_b;
   logic [4:0]  e_a;
   logic        e_r;
   logic        e_p;
   logic [16:0] e_ref;

   always #10 clk = ~clk;

   ser_prog_reg dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_le(ser_le), .div_b(div_b), .div_a(div_a), .cnt_reset(cnt_reset),
      .power_down(power_down), .b_invalid(b_invalid), .ref_word(ref_word));

   function automatic logic [17:0] pack(input logic [9:0] b, input logic [4:0] a,
                                        input logic r, input logic p, input logic addr);
      return {b, a, r, p, addr};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic v);
      @(negedge clk); ser_data = v;
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_word(input logic [17:0] w);
      for (int i = 17; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic latch(input logic [17:0] w);
      @(negedge clk); ser_le = 1'b1;
      repeat (6) @(negedge clk);
      ser_le = 1'b0;
      repeat (4) @(negedge clk);
      if (w[0]) e_ref = w[17:1];
      else {e_b, e_a, e_r, e_p} = w[17:1];
   endtask

   task automatic check_all(input string tag);
      chk({tag, " R3 div_b"}, 32'(div_b), 32'(e_b));
      chk({tag, " R3 div_a"}, 32'(div_a), 32'(e_a));
      chk({tag, " R3 cnt_reset"}, 32'(cnt_reset), 32'(e_r));
      chk({tag, " R3 power_down"}, 32'(power_down), 32'(e_p));
      chk({tag, " R4 ref_word"}, 32'(ref_word), 32'(e_ref));
      chk({tag, " R6 b_invalid"}, 32'(b_invalid), 32'(e_b < 10'd3));
   endtask

   task automatic load(input logic [17:0] w, input string tag);
      send_word(w);
      latch(w);
      check_all(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [17:0] w;
      void'($urandom(32'd20240611));
      e_b = '0; e_a = '0; e_r = 1'b0; e_p = 1'b0; e_ref = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R7 reset state
      chk("R7 div_b", 32'(div_b), 0);
      chk("R7 div_a", 32'(div_a), 0);
      chk("R7 ctl", 32'({cnt_reset, power_down}), 0);
      chk("R7 ref_word", 32'(ref_word), 0);
      chk("R7 b_invalid", 32'(b_invalid), 1);

      // R6 boundary B values
      load(pack(10'd0, 5'd7, 1'b0, 1'b1, 1'b0), "b0");
      load(pack(10'd1, 5'd31, 1'b1, 1'b0, 1'b0), "b1");
      load(pack(10'd2, 5'd0, 1'b1, 1'b1, 1'b0), "b2");
      load(pack(10'd3, 5'd1, 1'b0, 1'b0, 1'b0), "b3");
      load(pack(10'd1023, 5'd31, 1'b1, 1'b1, 1'b0), "bmax");

      // R2 R4 reference path leaves divider alone
      load(pack(10'd2, 5'd3, 1'b0, 1'b0, 1'b1), "ref");
      chk("R4 div untouched", 32'(div_b), 32'd1023);

      // R1 extra leading bits are pushed out
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      load(pack(10'h155, 5'h0A, 1'b1, 1'b0, 1'b0), "lead");

      // R5 le held high: extra bits shifted, outputs frozen
      send_word(pack(10'h2AA, 5'h15, 1'b0, 1'b1, 1'b0));
      @(negedge clk); ser_le = 1'b1;
      repeat (6) @(negedge clk);
      {e_b, e_a, e_r, e_p} = 17'(pack(10'h2AA, 5'h15, 1'b0, 1'b1, 1'b0) >> 1);
      check_all("le_hi");
      send_word(pack(10'd5, 5'd9, 1'b1, 1'b1, 1'b0));
      check_all("R5 held");
      @(negedge clk); ser_le = 1'b0;
      repeat (6) @(negedge clk);
      check_all("R5 fall");

      // R8 timing: visible on 3rd clk edge after le pin rises
      send_word(pack(10'd77, 5'd4, 1'b0, 1'b0, 1'b0));
      @(negedge clk); ser_le = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R8 not yet", 32'(div_b), 32'd5 == 32'(div_b) ? 32'd5 : 32'h2AA);
      @(negedge clk);
      chk("R8 landed", 32'(div_b), 32'd77);
      repeat (4) @(negedge clk); ser_le = 1'b0;
      repeat (4) @(negedge clk);
      e_b = 10'd77; e_a = 5'd4; e_r = 1'b0; e_p = 1'b0;

      // random words, both destinations
      for (int k = 0; k < 40; k++) begin
         w = 18'($urandom);
         if (k % 5 == 0) w[17:8] = 10'($urandom % 3);
         load(w, "rand");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule